// File: doc/BRIEF.md
# JPEG Coefficient Run-Length Decoder

This block sits between a Huffman symbol decoder and an inverse transform in a baseline JPEG decode pipeline. For each 8x8 block it takes one DC symbol and a sequence of AC symbols, each given with the raw magnitude bits that follow it in the bitstream. From these it rebuilds the 64 quantized DCT coefficients of the block and multiplies each by its dequantization factor. It keeps a separate DC predictor for each colour component. It turns zero-run/size symbols into zero runs and signed values. It places every coefficient at its natural row-major position by undoing the zigzag scan order.

Symbols enter on a valid/ready handshake, one symbol per clock. A resynchronization pulse clears all DC predictors. When a block is complete the block raises a one-cycle done strobe, with an error flag that is valid in the same cycle. The finished block can then be read through a combinational read port until the next DC symbol is accepted. Two dequantization tables are loaded through a write port. Component 0 uses table 0 and every other component uses table 1.

The sequencer has three states. ST_DC waits for the DC symbol of a new block. ST_AC consumes AC symbols. ST_DONE is the single done cycle. There are four transitions: ST_DC to ST_AC when a DC symbol is accepted. ST_AC to ST_AC when a value or a 16-zero run leaves positions unfilled. ST_AC to ST_DONE on end-of-block, when the block is full, or on an error. ST_DONE to ST_DC unconditionally on the next clock.

Top module: `coef_rle_decoder`

## Requirements
- R1: A DC symbol carries the bit count s in `sym_code[3:0]`. The difference is the low s bits of `sym_bits`: taken as positive when bit s-1 is 1, and equal to (bits - (2^s - 1)) when it is 0. A count of 0 gives a difference of 0. For example, s=8 with bits 01101000 gives -151.
- R2: Each component selected by `comp_sel` has its own predictor, which is 0 after reset. The DC coefficient is predictor + difference, and it becomes that component's new predictor. The other components are not affected.
- R3: A `resync` pulse sets every predictor to 0. If the pulse comes in the same cycle as an accepted DC symbol, that symbol is predicted from 0.
- R4: In an AC symbol, `sym_code[7:4]` is a count of zero positions to skip and `sym_code[3:0]` is the value bit count. The value is decoded with the R1 rule and lands at the zigzag position that follows the skipped zeros.
- R5: AC symbol 0x00 ends the block. All unwritten positions read 0, and `blk_done` is high in the cycle after that symbol is accepted.
- R6: AC symbol 0xF0 skips 16 zero positions and writes no value.
- R7: Zigzag position k is stored at natural index row*8+col, following the standard scan (0,1,8,16,9,2,3,10,17,...,62,63). `rd_addr` selects the natural index.
- R8: Every stored coefficient equals the decoded value times entry [natural index] of table 0 (component 0) or table 1 (other components). Tables are written by `qt_we` at `qt_tbl`/`qt_addr`.
- R9: A value whose position would exceed 63, a 0xF0 run that would pass 64, or any other AC symbol with a bit count of 0 ends the block with `blk_err` high during the done cycle. Coefficients written earlier are kept.
- R10: Accepting a DC symbol clears the previous block, so that every position other than 0 reads 0 until it is written again.
- R11: A block also ends without an end-of-block symbol when position 63 receives a value or a 0xF0 run ends exactly at 64. In that case `blk_err` is low.
- R12: `sym_ready` is high in ST_DC and ST_AC and low in the done cycle. `blk_done` lasts one cycle and is followed by ST_DC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_valid | input | 1 | Symbol and bits are valid |
| sym_ready | output | 1 | Block accepts a symbol this cycle |
| sym_code | input | 8 | Decoded Huffman symbol (run/size) |
| sym_bits | input | MAG_W (11) | Raw magnitude bits, right-aligned |
| comp_sel | input | CW (2) | Colour component of the block, sampled with the DC symbol |
| resync | input | 1 | Restart pulse, clears all DC predictors |
| qt_we | input | 1 | Dequantization table write enable |
| qt_tbl | input | 1 | Table select for the write |
| qt_addr | input | 6 | Natural index for the write |
| qt_val | input | QW (8) | Unsigned table entry |
| rd_addr | input | 6 | Natural index to read |
| blk_done | output | 1 | One-cycle block-complete strobe |
| blk_err | output | 1 | Block ended on an overflow or invalid symbol |
| rd_coef | output | COEF_W (24) | Signed dequantized coefficient at `rd_addr` |

## Verification
The assertions assume that `resync` arrives only while a DC symbol is awaited, that DC bit counts never exceed 11, and that tables are not rewritten in the middle of a block. The directed stimulus loads both tables before the first block and raises `resync` only between blocks, alone or together with a DC symbol. It also reads the coefficient buffer only between blocks, and it keeps every bit count inside the magnitude width.

// File: rtl/coef_rle_pkg.sv
package coef_rle_pkg;

    typedef enum logic [1:0] {
        ST_DC   = 2'd0,
        ST_AC   = 2'd1,
        ST_DONE = 2'd2
    } rle_state_e;

    // Walk the zigzag scan k steps from the top-left corner and
    // return the natural row-major index reached.
    function automatic logic [5:0] zz_nat(input int k);
        int r;
        int c;
        r = 0;
        c = 0;
        for (int s = 0; s < 64; s++) begin
            if (s < k) begin
                if (((r + c) % 2) == 0) begin
                    if (c == 7)      r = r + 1;
                    else if (r == 0) c = c + 1;
                    else begin r = r - 1; c = c + 1; end
                end else begin
                    if (r == 7)      c = c + 1;
                    else if (c == 0) r = r + 1;
                    else begin r = r + 1; c = c - 1; end
                end
            end
        end
        return 6'(r * 8 + c);
    endfunction

endpackage

// File: rtl/mag_extend.sv
module mag_extend #(
    parameter int MAG_W = 11,
    parameter int VAL_W = 16
) (
    input  logic [3:0]              size,
    input  logic [MAG_W-1:0]        bits,
    output logic signed [VAL_W-1:0] val
);
    logic [VAL_W-1:0] lim;
    logic [VAL_W-1:0] raw;
    logic             msb;

    always_comb begin
        lim = (VAL_W'(1) << size) - VAL_W'(1);
        raw = VAL_W'(bits) & lim;
        msb = |(raw & (lim ^ (lim >> 1)));
        if (size == 4'd0)
            val = '0;
        else if (msb)
            val = signed'(raw);
        else
            val = signed'(raw - lim);
    end
endmodule

// File: rtl/zz_map.sv
module zz_map (
    input  logic [5:0] zz_idx,
    output logic [5:0] nat_idx
);
    logic [5:0] lut [64];

    for (genvar g = 0; g < 64; g++) begin : g_lut
        assign lut[g] = coef_rle_pkg::zz_nat(g);
    end

    assign nat_idx = lut[zz_idx];
endmodule

// File: rtl/quant_tab.sv
module quant_tab #(
    parameter int QW     = 8,
    parameter int NUM_QT = 2,
    localparam int TW    = (NUM_QT > 1) ? $clog2(NUM_QT) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [TW-1:0] wr_tbl,
    input  logic [5:0]    wr_idx,
    input  logic [QW-1:0] wr_val,
    input  logic [TW-1:0] rd_tbl,
    input  logic [5:0]    rd_idx,
    output logic [QW-1:0] rd_val
);
    logic [QW-1:0] mem [NUM_QT*64];

    always_ff @(posedge clk) begin
        if (we)
            mem[{wr_tbl, wr_idx}] <= wr_val;
    end

    assign rd_val = mem[{rd_tbl, rd_idx}];
endmodule

// File: rtl/coef_store.sv
module coef_store #(
    parameter int COEF_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_clear,
    input  logic [5:0]               wr_idx,
    input  logic signed [COEF_W-1:0] wr_val,
    input  logic [5:0]               rd_idx,
    output logic signed [COEF_W-1:0] rd_val
);
    logic [COEF_W-1:0] mem [64];
    logic [63:0]       written_q;

    // A set bit marks a position written in the current block; others read zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            written_q <= '0;
        else if (wr_en) begin
            if (wr_clear)
                written_q <= 64'd1 << wr_idx;
            else
                written_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_val;
    end

    assign rd_val = written_q[rd_idx] ? signed'(mem[rd_idx]) : '0;
endmodule

// File: rtl/coef_rle_decoder.sv
module coef_rle_decoder
    import coef_rle_pkg::*;
#(
    parameter int NUM_COMP  = 4,
    parameter int MAG_W     = 11,
    parameter int VAL_W     = 16,
    parameter int QW        = 8,
    localparam int CW       = (NUM_COMP > 1) ? $clog2(NUM_COMP) : 1,
    localparam int COEF_W   = VAL_W + QW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sym_valid,
    output logic                     sym_ready,
    input  logic [7:0]               sym_code,
    input  logic [MAG_W-1:0]         sym_bits,
    input  logic [CW-1:0]            comp_sel,
    input  logic                     resync,
    input  logic                     qt_we,
    input  logic                     qt_tbl,
    input  logic [5:0]               qt_addr,
    input  logic [QW-1:0]            qt_val,
    input  logic [5:0]               rd_addr,
    output logic                     blk_done,
    output logic                     blk_err,
    output logic signed [COEF_W-1:0] rd_coef
);
    localparam int NUM_QT = 2;

    rle_state_e state_q, state_d;
    logic [5:0]              pos_q, pos_d;
    logic [CW-1:0]           comp_q;
    logic                    err_q;
    logic signed [VAL_W-1:0] pred_q [NUM_COMP];

    logic                    accept;
    logic [3:0]              run_len;
    logic [3:0]              bit_cnt;
    logic signed [VAL_W-1:0] mag_val;
    logic signed [VAL_W-1:0] pred_base;
    logic signed [VAL_W-1:0] dc_val;
    logic [6:0]              tgt_pos;
    logic [6:0]              zrl_pos;
    logic [5:0]              zz_idx;
    logic [5:0]              nat_idx;
    logic [CW-1:0]           comp_eff;
    logic                    q_tbl;
    logic [QW-1:0]           q_val;
    logic signed [VAL_W-1:0] wr_val;
    logic signed [COEF_W-1:0] wr_coef;

    logic wr_en, wr_clear, err_set, err_clr, pred_wr;

    assign accept  = sym_valid && sym_ready;
    assign run_len = sym_code[7:4];
    assign bit_cnt = sym_code[3:0];

    mag_extend #(.MAG_W(MAG_W), .VAL_W(VAL_W)) u_ext (
        .size (bit_cnt),
        .bits (sym_bits),
        .val  (mag_val)
    );

    assign pred_base = resync ? '0 : pred_q[comp_sel];
    assign dc_val    = pred_base + mag_val;
    assign tgt_pos   = {1'b0, pos_q} + 7'(run_len);
    assign zrl_pos   = {1'b0, pos_q} + 7'd16;
    assign zz_idx    = (state_q == ST_DC) ? 6'd0 : tgt_pos[5:0];
    assign comp_eff  = (state_q == ST_DC) ? comp_sel : comp_q;
    assign q_tbl     = (comp_eff == '0) ? 1'b0 : 1'b1;
    assign wr_val    = (state_q == ST_DC) ? dc_val : mag_val;
    assign wr_coef   = wr_val * signed'({1'b0, q_val});

    zz_map u_zz (
        .zz_idx  (zz_idx),
        .nat_idx (nat_idx)
    );

    quant_tab #(.QW(QW), .NUM_QT(NUM_QT)) u_qt (
        .clk    (clk),
        .we     (qt_we),
        .wr_tbl (qt_tbl),
        .wr_idx (qt_addr),
        .wr_val (qt_val),
        .rd_tbl (q_tbl),
        .rd_idx (nat_idx),
        .rd_val (q_val)
    );

    coef_store #(.COEF_W(COEF_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_clear (wr_clear),
        .wr_idx   (nat_idx),
        .wr_val   (wr_coef),
        .rd_idx   (rd_addr),
        .rd_val   (rd_coef)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_DC;
        else
            state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        pos_d     = pos_q;
        wr_en     = 1'b0;
        wr_clear  = 1'b0;
        err_set   = 1'b0;
        err_clr   = 1'b0;
        pred_wr   = 1'b0;
        sym_ready = 1'b0;
        blk_done  = 1'b0;
        unique case (state_q)
            ST_DC: begin
                sym_ready = 1'b1;
                if (accept) begin
                    wr_en    = 1'b1;
                    wr_clear = 1'b1;
                    pred_wr  = 1'b1;
                    err_clr  = 1'b1;
                    pos_d    = 6'd1;
                    state_d  = ST_AC;
                end
            end
            ST_AC: begin
                sym_ready = 1'b1;
                if (accept) begin
                    if (sym_code == 8'h00) begin
                        state_d = ST_DONE;
                    end else if (sym_code == 8'hF0) begin
                        if (zrl_pos > 7'd64) begin
                            err_set = 1'b1;
                            state_d = ST_DONE;
                        end else if (zrl_pos == 7'd64) begin
                            state_d = ST_DONE;
                        end else begin
                            pos_d = zrl_pos[5:0];
                        end
                    end else if (bit_cnt == 4'd0 || tgt_pos > 7'd63) begin
                        err_set = 1'b1;
                        state_d = ST_DONE;
                    end else begin
                        wr_en = 1'b1;
                        if (tgt_pos == 7'd63)
                            state_d = ST_DONE;
                        else
                            pos_d = tgt_pos[5:0] + 6'd1;
                    end
                end
            end
            ST_DONE: begin
                blk_done = 1'b1;
                state_d  = ST_DC;
            end
            default: state_d = ST_DC;
        endcase
    end

    // Sequencer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= '0;
            comp_q <= '0;
            err_q  <= 1'b0;
            for (int i = 0; i < NUM_COMP; i++)
                pred_q[i] <= '0;
        end else begin
            pos_q <= pos_d;
            if (err_clr)
                err_q <= 1'b0;
            else if (err_set)
                err_q <= 1'b1;
            if (pred_wr)
                comp_q <= comp_sel;
            for (int i = 0; i < NUM_COMP; i++) begin
                if (pred_wr && comp_sel == CW'(i))
                    pred_q[i] <= dc_val;
                else if (resync)
                    pred_q[i] <= '0;
            end
        end
    end

    assign blk_err = err_q;

endmodule

// File: rtl/coef_rle_checker.sv
module coef_rle_checker
    import coef_rle_pkg::*;
#(
    parameter int COEF_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sym_valid,
    input logic              sym_ready,
    input logic [7:0]        sym_code,
    input logic              blk_done,
    input logic              blk_err,
    input logic [5:0]        rd_addr,
    input logic [COEF_W-1:0] rd_coef,
    input rle_state_e        state_q
);
    logic acc_dc;
    logic acc_eob;
    assign acc_dc  = sym_valid && sym_ready && state_q == ST_DC;
    assign acc_eob = sym_valid && sym_ready && state_q == ST_AC && sym_code == 8'h00;

    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);

    a_r12_no_ready_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> !sym_ready);

    a_r12_dc_then_ac: assert property (@(posedge clk) disable iff (!rst_n)
        acc_dc |=> (state_q == ST_AC && !blk_done && sym_ready));

    a_r5_eob_done: assert property (@(posedge clk) disable iff (!rst_n)
        acc_eob |=> blk_done);

    a_r9_err_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_err) |-> blk_done);

    a_r10_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc_dc) && rd_addr != 6'd0) |-> (rd_coef == '0));
endmodule

bind coef_rle_decoder coef_rle_checker #(.COEF_W(COEF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .sym_ready (sym_ready),
    .sym_code  (sym_code),
    .blk_done  (blk_done),
    .blk_err   (blk_err),
    .rd_addr   (rd_addr),
    .rd_coef   (rd_coef),
    .state_q   (state_q)
);

// File: tb/sim_coef_rle_decoder.sv
`timescale 1ns/1ps
module sim_coef_rle_decoder;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sym_valid = 1'b0;
    logic               sym_ready;
    logic [7:0]         sym_code = '0;
    logic [10:0]        sym_bits = '0;
    logic [1:0]         comp_sel = '0;
    logic               resync = 1'b0;
    logic               qt_we = 1'b0;
    logic               qt_tbl = 1'b0;
    logic [5:0]         qt_addr = '0;
    logic [7:0]         qt_val = '0;
    logic [5:0]         rd_addr = '0;
    logic               blk_done;
    logic               blk_err;
    logic signed [23:0] rd_coef;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int zz_tab [64] = '{0,1,8,16,9,2,3,10,17,24,32,25,18,11,4,5,
                        12,19,26,33,40,48,41,34,27,20,13,6,7,14,21,28,
                        35,42,49,56,57,50,43,36,29,22,15,23,30,37,44,51,
                        58,59,52,45,38,31,39,46,53,60,61,54,47,55,62,63};
    int exp_blk [64];
    int pred [4];
    int mpos;
    int mcomp;
    bit mdone;
    bit merr;

    always #2.5 clk = ~clk;

    coef_rle_decoder u0 (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
        .sym_code(sym_code), .sym_bits(sym_bits), .comp_sel(comp_sel),
        .resync(resync), .qt_we(qt_we), .qt_tbl(qt_tbl), .qt_addr(qt_addr),
        .qt_val(qt_val), .rd_addr(rd_addr), .blk_done(blk_done),
        .blk_err(blk_err), .rd_coef(rd_coef)
    );

    function automatic int qv(input int comp, input int nat);
        return (comp == 0) ? (nat % 7) + 1 : (nat % 5) + 2;
    endfunction

    function automatic int ext(input int s, input int b);
        int m;
        if (s == 0) return 0;
        m = (1 << s) - 1;
        b = b & m;
        if (((b >> (s - 1)) & 1) == 1) return b;
        return b - m;
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic send(input logic [7:0] code, input logic [10:0] bits,
                        input logic [1:0] comp, input logic rs);
        @(negedge clk);
        sym_valid = 1'b1; sym_code = code; sym_bits = bits;
        comp_sel = comp; resync = rs;
        while (!sym_ready) @(negedge clk);
        @(posedge clk);
        #1;
        sym_valid = 1'b0; resync = 1'b0;
    endtask

    task automatic pulse_resync();
        @(negedge clk);
        resync = 1'b1;
        @(posedge clk);
        #1 resync = 1'b0;
        for (int i = 0; i < 4; i++) pred[i] = 0;
    endtask

    task automatic dc(input int comp, input int s, input logic [10:0] bits,
                      input logic rs);
        int d;
        if (rs) for (int i = 0; i < 4; i++) pred[i] = 0;
        for (int i = 0; i < 64; i++) exp_blk[i] = 0;
        d = ext(s, int'(bits));
        pred[comp] = pred[comp] + d;
        mcomp = comp;
        exp_blk[0] = pred[comp] * qv(comp, 0);
        mpos = 1; mdone = 0; merr = 0;
        send(8'(s), bits, 2'(comp), rs);
    endtask

    task automatic ac(input logic [7:0] code, input logic [10:0] bits);
        int run, sz, t;
        run = int'(code[7:4]);
        sz  = int'(code[3:0]);
        send(code, bits, 2'(mcomp), 1'b0);
        if (code == 8'h00) mdone = 1;
        else if (code == 8'hF0) begin
            t = mpos + 16;
            if (t > 64) begin merr = 1; mdone = 1; end
            else if (t == 64) mdone = 1;
            else mpos = t;
        end else if (sz == 0) begin merr = 1; mdone = 1; end
        else begin
            t = mpos + run;
            if (t > 63) begin merr = 1; mdone = 1; end
            else begin
                exp_blk[zz_tab[t]] = ext(sz, int'(bits)) * qv(mcomp, zz_tab[t]);
                if (t == 63) mdone = 1; else mpos = t + 1;
            end
        end
    endtask

    // Done must appear in the cycle right after the final symbol (R5, R11, R12).
    task automatic finish_block(input string tag);
        @(negedge clk);
        check({tag, " R12 done one cycle after last symbol"}, int'(blk_done), 1);
        check({tag, " R12 ready low while done"}, int'(sym_ready), 0);
        check({tag, " R9 error flag"}, int'(blk_err), int'(merr));
        check({tag, " model reached block end"}, int'(mdone), 1);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            rd_addr = 6'(i);
            #0.5;
            check($sformatf("%s R7 R8 coef[%0d]", tag, i), int'(rd_coef), exp_blk[i]);
        end
    endtask

    task automatic t_reset();
        check("R12 reset done low", int'(blk_done), 0);
        check("R12 reset ready high", int'(sym_ready), 1);
        check("R9 reset err low", int'(blk_err), 0);
    endtask

    task automatic t_basic();
        dc(0, 8, 11'b01101000, 1'b0);
        check("R1 model dc -151", pred[0], -151);
        ac(8'h05, 11'b10011);
        ac(8'h23, 11'b010);
        ac(8'h00, 11'd0);
        finish_block("R1 R4 R5 basic");
    endtask

    task automatic t_components();
        dc(0, 2, 11'b11, 1'b0);
        ac(8'h00, 11'd0);
        finish_block("R2 comp0 second");
        dc(1, 4, 11'b1010, 1'b0);
        ac(8'h12, 11'b01);
        ac(8'h00, 11'd0);
        finish_block("R2 comp1 first");
    endtask

    task automatic t_resync();
        pulse_resync();
        dc(0, 1, 11'b1, 1'b0);
        ac(8'h00, 11'd0);
        finish_block("R3 resync alone");
        dc(1, 1, 11'b0, 1'b1);
        ac(8'h00, 11'd0);
        finish_block("R3 resync with dc");
    endtask

    task automatic t_zrl();
        dc(2, 0, 11'd0, 1'b0);
        ac(8'hF0, 11'd0);
        ac(8'hF0, 11'd0);
        ac(8'h31, 11'b1);
        ac(8'h00, 11'd0);
        finish_block("R6 R1 zero runs");
    endtask

    task automatic t_full();
        dc(0, 3, 11'b101, 1'b0);
        for (int k = 1; k < 64; k++)
            ac(8'h01, 11'(k % 2));
        finish_block("R11 full block");
        dc(3, 2, 11'b10, 1'b0);
        ac(8'hF0, 11'd0);
        ac(8'hF0, 11'd0);
        ac(8'hE2, 11'b11);
        ac(8'hF0, 11'd0);
        finish_block("R10 R11 zrl ends at 64");
    endtask

    task automatic t_errors();
        dc(1, 2, 11'b01, 1'b0);
        ac(8'hF0, 11'd0);
        ac(8'hF0, 11'd0);
        ac(8'hF0, 11'd0);
        ac(8'hF1, 11'b1);
        finish_block("R9 value past 63");
        dc(0, 1, 11'b1, 1'b0);
        ac(8'hF0, 11'd0);
        ac(8'hF0, 11'd0);
        ac(8'hF0, 11'd0);
        ac(8'h01, 11'b1);
        ac(8'hF0, 11'd0);
        finish_block("R9 zrl past 64");
        dc(2, 1, 11'b0, 1'b0);
        ac(8'h02, 11'b11);
        ac(8'h30, 11'd0);
        finish_block("R9 invalid size zero");
        dc(2, 0, 11'd0, 1'b0);
        ac(8'h00, 11'd0);
        finish_block("R9 R10 err cleared next block");
    endtask

    initial begin
        for (int i = 0; i < 4; i++) pred[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int t = 0; t < 2; t++) begin
            for (int i = 0; i < 64; i++) begin
                @(negedge clk);
                qt_we = 1'b1; qt_tbl = 1'(t); qt_addr = 6'(i);
                qt_val = 8'(qv(t, i));
            end
        end
        @(negedge clk);
        qt_we = 1'b0;
        t_basic();
        t_components();
        t_resync();
        t_zrl();
        t_full();
        t_errors();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule